// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Controller

This block is a register-mapped bank of identical PWM generators. Each channel has an 8-bit clock divider, an 18-bit period and an 18-bit duty count. It also has a polarity select, so its output line can idle high or low. A processor programs the bank over a plain 16-bit register bus. Each 18-bit count is split across two half-words that sit 4 bytes apart.

One shared control word holds one soft-reset bit per channel. A channel whose bit is set is stopped, its counters are cleared and its line sits at the inactive level. A channel whose bit is clear counts. Writes to duty, period and divider land in shadow copies. A running channel takes these into use only at the end of its current period, so a waveform never shows a torn cycle. A channel that is held picks them up at once, so it starts with fresh settings when released.

The channel count is a parameter: 8 for the full bank, 4 for the reduced one.

Top module: `pwm_bank`

## Requirements
- R1: After the synchronous reset every register reads 0, every soft-reset bit is 0 (all channels run), and every PWM output is 0.
- R2: Written values read back. The high half-words of duty and period keep only bits 1:0 (count bits 17:16). The divider keeps bits 7:0. The control word keeps only bit 4. The soft-reset word keeps one bit per channel. All other bits read 0.
- R3: Read data appears on `bus_rdata` in the cycle after `bus_rd`. It is 0 in any cycle that follows no read, and reads of unmapped byte addresses return 0.
- R4: A running channel counts 0..period-1, advancing once every (divider+1) clocks. Its raw output is 1 while count < duty, so over whole periods the output is high for (divider+1)*duty clocks of every (divider+1)*period.
- R5: A duty value at or above the period gives a constant active level. Period 0 with duty 0 gives a constant inactive level.
- R6: Control bit 4 set inverts the output, so the high time becomes the complement within the period.
- R7: Writes to duty, period or divider of a running channel do not alter the period in progress. They take effect from the next period.
- R8: Clearing a channel's soft-reset bit starts it at count 0 with the values last written. The output is active in the second cycle after the write strobe when duty > 0.
- R9: While its soft-reset bit is 1, a channel's counter and prescaler are 0 and its output equals its polarity bit (the inactive level).
- R10: Channel n's registers sit at byte offset 0x80*n: duty low +0x08, duty high +0x0C, period low +0x10, period high +0x14, divider +0x18, control +0x1C. The soft-reset word is at 0x1FC, with bit i for channel i. Channels run independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W (10) | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, valid the cycle after `bus_rd` |
| pwm_out | output | NCH (8) | One registered PWM line per channel |

## Verification
A counter or prescaler that escapes its range shows as a stretched or shortened period within one period length. A wrong load moment shows as a torn pulse in the period where the write happened, visible within the next edge. High-time counts taken over whole periods expose any divider or compare error at the ports, and a channel held in soft reset that drives the active level is visible in the very next cycle. Register decode faults appear on the next read as a wrong or non-zero word.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int BUS_W       = 16;
  localparam int STRIDE_LG   = 7;          // 0x80 bytes per channel
  localparam logic [6:0] OFF_DUTY_LO = 7'h08;
  localparam logic [6:0] OFF_DUTY_HI = 7'h0C;
  localparam logic [6:0] OFF_PER_LO  = 7'h10;
  localparam logic [6:0] OFF_PER_HI  = 7'h14;
  localparam logic [6:0] OFF_DIV     = 7'h18;
  localparam logic [6:0] OFF_CTRL    = 7'h1C;
  localparam int POL_BIT     = 4;
  localparam int SRST_ADDR   = 'h1FC;

  function automatic int addr_width(input int nch);
    int w;
    w = $clog2(nch) + STRIDE_LG;
    if (w < 9) w = 9;                      // must reach the soft-reset word
    return w;
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CNT_W  = 18,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [BUS_W-1:0]            bus_wdata,
  output logic [BUS_W-1:0]            bus_rdata,
  output logic [NCH-1:0][CNT_W-1:0]   sh_duty,
  output logic [NCH-1:0][CNT_W-1:0]   sh_per,
  output logic [NCH-1:0][DIV_W-1:0]   sh_div,
  output logic [NCH-1:0]              pol,
  output logic [NCH-1:0]              srst
);
  localparam int HI_W = CNT_W - BUS_W;
  localparam int CH_W = ADDR_W - STRIDE_LG;

  logic [CH_W-1:0]  ch_sel;
  logic [6:0]       off;
  logic             srst_hit;
  logic             ch_ok;
  logic [BUS_W-1:0] rd_val;

  assign ch_sel   = bus_addr[ADDR_W-1:STRIDE_LG];
  assign off      = bus_addr[STRIDE_LG-1:0];
  assign srst_hit = (bus_addr == ADDR_W'(SRST_ADDR));
  assign ch_ok    = ({1'b0, ch_sel} < (CH_W+1)'(NCH));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel;
    assign sel = bus_wr && ch_ok && (ch_sel == CH_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        sh_duty[g] <= '0;
        sh_per[g]  <= '0;
        sh_div[g]  <= '0;
        pol[g]     <= 1'b0;
      end else if (sel) begin
        case (off)
          OFF_DUTY_LO: sh_duty[g][BUS_W-1:0]     <= bus_wdata;
          OFF_DUTY_HI: sh_duty[g][CNT_W-1:BUS_W] <= bus_wdata[HI_W-1:0];
          OFF_PER_LO:  sh_per[g][BUS_W-1:0]      <= bus_wdata;
          OFF_PER_HI:  sh_per[g][CNT_W-1:BUS_W]  <= bus_wdata[HI_W-1:0];
          OFF_DIV:     sh_div[g]                 <= bus_wdata[DIV_W-1:0];
          OFF_CTRL:    pol[g]                    <= bus_wdata[POL_BIT];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    srst <= '0;
    else if (bus_wr && srst_hit) srst <= bus_wdata[NCH-1:0];
  end

  always_comb begin
    rd_val = '0;
    if (srst_hit) begin
      rd_val[NCH-1:0] = srst;
    end else if (ch_ok) begin
      for (int k = 0; k < NCH; k++) begin
        if (ch_sel == CH_W'(k)) begin
          case (off)
            OFF_DUTY_LO: rd_val = sh_duty[k][BUS_W-1:0];
            OFF_DUTY_HI: rd_val[HI_W-1:0] = sh_duty[k][CNT_W-1:BUS_W];
            OFF_PER_LO:  rd_val = sh_per[k][BUS_W-1:0];
            OFF_PER_HI:  rd_val[HI_W-1:0] = sh_per[k][CNT_W-1:BUS_W];
            OFF_DIV:     rd_val[DIV_W-1:0] = sh_div[k];
            OFF_CTRL:    rd_val[POL_BIT] = pol[k];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_rd ? rd_val : '0;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W = 18,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             pol,
  input  logic [CNT_W-1:0] sh_duty,
  input  logic [CNT_W-1:0] sh_per,
  input  logic [DIV_W-1:0] sh_div,
  output logic             pwm_o,
  output logic [CNT_W-1:0] cnt,
  output logic [DIV_W-1:0] pre,
  output logic [CNT_W-1:0] act_duty,
  output logic [CNT_W-1:0] act_per,
  output logic [DIV_W-1:0] act_div
);
  logic tick;
  logic last;

  assign tick = (pre == act_div);
  assign last = ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, act_per};

  always_ff @(posedge clk) begin
    if (rst) begin
      pre      <= '0;
      cnt      <= '0;
      act_duty <= '0;
      act_per  <= '0;
      act_div  <= '0;
      pwm_o    <= 1'b0;
    end else if (hold) begin
      pre      <= '0;
      cnt      <= '0;
      act_duty <= sh_duty;
      act_per  <= sh_per;
      act_div  <= sh_div;
      pwm_o    <= pol;
    end else begin
      if (tick) begin
        pre <= '0;
        if (last) begin
          cnt      <= '0;
          act_duty <= sh_duty;
          act_per  <= sh_per;
          act_div  <= sh_div;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end else begin
        pre <= pre + DIV_W'(1);
      end
      pwm_o <= (cnt < act_duty) ^ pol;
    end
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CNT_W  = 18,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = addr_width(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  logic [NCH-1:0][CNT_W-1:0] sh_duty, sh_per;
  logic [NCH-1:0][DIV_W-1:0] sh_div;
  logic [NCH-1:0]            pol_q, srst_q;
  logic [NCH-1:0][CNT_W-1:0] cnt_w, act_duty_w, act_per_w;
  logic [NCH-1:0][DIV_W-1:0] pre_w, act_div_w;

  pwm_regs #(.NCH(NCH), .CNT_W(CNT_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sh_duty(sh_duty), .sh_per(sh_per), .sh_div(sh_div),
    .pol(pol_q), .srst(srst_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pwm_chan #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chan (
      .clk(clk), .rst(rst), .hold(srst_q[g]), .pol(pol_q[g]),
      .sh_duty(sh_duty[g]), .sh_per(sh_per[g]), .sh_div(sh_div[g]),
      .pwm_o(pwm_out[g]), .cnt(cnt_w[g]), .pre(pre_w[g]),
      .act_duty(act_duty_w[g]), .act_per(act_per_w[g]), .act_div(act_div_w[g])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH   = 8,
  parameter int CNT_W = 18,
  parameter int DIV_W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_rd,
  input logic [15:0]               bus_rdata,
  input logic [NCH-1:0]            pwm_out,
  input logic [NCH-1:0]            srst,
  input logic [NCH-1:0]            pol,
  input logic [NCH-1:0][CNT_W-1:0] cnt,
  input logic [NCH-1:0][DIV_W-1:0] pre,
  input logic [NCH-1:0][CNT_W-1:0] act_duty,
  input logic [NCH-1:0][CNT_W-1:0] act_per,
  input logic [NCH-1:0][DIV_W-1:0] act_div
);
  p_rd_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == 16'h0);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    p_hold_inactive_r9: assert property (@(posedge clk) disable iff (rst)
      srst[i] |=> pwm_out[i] == $past(pol[i]));
    p_hold_clear_r9: assert property (@(posedge clk) disable iff (rst)
      srst[i] |=> (cnt[i] == '0 && pre[i] == '0));
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
      (!srst[i] && act_per[i] != '0) |-> cnt[i] < act_per[i]);
    p_pre_range_r4: assert property (@(posedge clk) disable iff (rst)
      !srst[i] |-> pre[i] <= act_div[i]);
    p_full_duty_r5: assert property (@(posedge clk) disable iff (rst)
      (!srst[i] && act_per[i] != '0 && act_duty[i] >= act_per[i])
      |=> pwm_out[i] == !$past(pol[i]));
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !srst[i] |=> (cnt[i] == '0 ||
                    ($stable(act_duty[i]) && $stable(act_per[i]))));
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .pwm_out(pwm_out), .srst(srst_q), .pol(pol_q), .cnt(cnt_w), .pre(pre_w),
  .act_duty(act_duty_w), .act_per(act_per_w), .act_div(act_div_w)
);

// File: tb/sim_pwm_bank.sv
module sim_pwm_bank;
  import pwm_bank_pkg::*;
  localparam int NCH    = 8;
  localparam int ADDR_W = addr_width(NCH);
  localparam int NV     = 8;
  // stimulus: divider, period, duty, polarity; expected: window, high clocks
  localparam int V_DIV [NV] = '{0, 0, 0, 3, 1, 2, 0, 255};
  localparam int V_PER [NV] = '{10, 10, 10, 7, 20, 5, 1, 3};
  localparam int V_DUTY[NV] = '{3, 0, 10, 2, 5, 9, 0, 1};
  localparam int V_POL [NV] = '{0, 0, 0, 0, 1, 0, 0, 0};
  localparam int V_WIN [NV] = '{40, 40, 40, 112, 160, 60, 4, 3072};
  localparam int V_HIGH[NV] = '{12, 0, 40, 32, 120, 60, 0, 1024};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [NCH-1:0] pwm_out;
  int checks = 0, errors = 0;
  int cyc = 0;

  pwm_bank #(.NCH(NCH)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic setup(input int ch, input int dv, input int per, input int duty, input int pl);
    int b;
    b = ch * 'h80;
    wr(b + 'h1C, pl << 4);
    wr(b + 'h18, dv);
    wr(b + 'h10, per & 'hFFFF);
    wr(b + 'h14, per >> 16);
    wr(b + 'h08, duty & 'hFFFF);
    wr(b + 'h0C, duty >> 16);
  endtask

  task automatic wait_rise(input int ch);
    logic prev;
    prev = pwm_out[ch];
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (!prev && pwm_out[ch]) return;
      prev = pwm_out[ch];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d, hi, t0, t1, n, h0, h1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(pwm_out == '0, "R1 outputs low", int'(pwm_out), 0);
    rd('h1FC, d); chk(d == 0, "R1 soft-reset word", d, 0);
    rd('h008, d); chk(d == 0, "R1 duty reset", d, 0);
    rd('h39C, d); chk(d == 0, "R1 ctrl reset", d, 0);

    // R2, R10: readback and masking
    wr('h108, 'h1234); rd('h108, d); chk(d == 'h1234, "R2 R10 duty low ch2", d, 'h1234);
    wr('h10C, 'hFFFF); rd('h10C, d); chk(d == 3, "R2 duty high mask", d, 3);
    wr('h118, 'hABCD); rd('h118, d); chk(d == 'hCD, "R2 divider mask", d, 'hCD);
    wr('h11C, 'hFFFF); rd('h11C, d); chk(d == 'h10, "R2 ctrl mask", d, 'h10);
    wr('h390, 'h5555); rd('h390, d); chk(d == 'h5555, "R10 period low ch7", d, 'h5555);
    wr('h314, 'hFFFF); rd('h314, d); chk(d == 3, "R2 period high ch6", d, 3);
    wr('h1FC, 'hFFFF); rd('h1FC, d); chk(d == 'hFF, "R2 soft-reset mask", d, 'hFF);
    // R3: unmapped reads and idle read data
    rd('h100, d); chk(d == 0, "R3 unmapped 0x100", d, 0);
    rd('h120, d); chk(d == 0, "R3 unmapped 0x120", d, 0);
    rd('h1F8, d); chk(d == 0, "R3 unmapped 0x1F8", d, 0);
    @(negedge clk); chk(bus_rdata == 0, "R3 idle read data", int'(bus_rdata), 0);

    // R9: held channels drive their polarity level
    setup(0, 0, 4, 2, 1);
    repeat (3) @(negedge clk);
    n = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); n += pwm_out[0]; end
    chk(n == 20, "R9 held inverted channel stays high", n, 20);
    chk(pwm_out[1] == 1'b0, "R9 held normal channel low", pwm_out[1], 0);

    // table: R4 R5 R6 on channel 0
    for (int v = 0; v < NV; v++) begin
      wr('h1FC, 'hFF);
      setup(0, V_DIV[v], V_PER[v], V_DUTY[v], V_POL[v]);
      wr('h1FC, 'hFE);
      repeat (2) @(negedge clk);
      hi = 0;
      for (int k = 0; k < V_WIN[v]; k++) begin @(negedge clk); hi += pwm_out[0]; end
      chk(hi == V_HIGH[v], $sformatf("R4 R5 R6 vector %0d high clocks", v), hi, V_HIGH[v]);
    end

    // R8: release start timing, count from 0
    wr('h1FC, 'hFF);
    setup(0, 0, 6, 3, 0);
    wr('h1FC, 'hFE);
    chk(pwm_out[0] == 1'b0, "R8 still inactive after strobe", pwm_out[0], 0);
    n = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (pwm_out[0] == (k < 3)) n++;
    end
    chk(n == 6, "R8 first period shape", n, 6);

    // R10: channels independent
    wr('h1FC, 'hFF);
    setup(1, 0, 4, 2, 0);
    setup(0, 0, 4, 4, 0);
    wr('h1FC, 'hFD);
    repeat (2) @(negedge clk);
    h0 = 0; h1 = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); h0 += pwm_out[0]; h1 += pwm_out[1];
    end
    chk(h1 == 20, "R10 channel 1 runs", h1, 20);
    chk(h0 == 0, "R10 channel 0 held", h0, 0);

    // R7: duty change mid-period waits for the period end
    wr('h1FC, 'hFF);
    setup(0, 0, 100, 10, 0);
    wr('h1FC, 'hFE);
    wait_rise(0); t0 = cyc;
    repeat (50) @(negedge clk);
    wr('h008, 80);
    wait_rise(0); t1 = cyc;
    chk(t1 - t0 == 100, "R7 period not torn", t1 - t0, 100);
    n = 1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (!pwm_out[0]) break;
      n++;
    end
    chk(n == 80, "R7 new duty in next period", n, 80);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule